// File: doc/BRIEF.md
# Processor Context Save/Restore Controller

This block sits between an unmodified soft processor and its program and data memories. While a task runs, fetches and data accesses pass straight through. On a suspend request it takes over the fetch port and feeds the core one store instruction per register. At the same time it cuts the data port off from task data memory and steers those stores into a small internal context store. That store has one slot per task. The fetch address of the first instruction that was not executed is kept in the same slot as the resume point.

On a resume request the block feeds load instructions that refill the registers from the chosen slot. The zero register is skipped when it is hardwired. The last injected instruction is an unconditional jump to the saved resume point, and from the next cycle on the program memory feeds the core again. The core needs no kernel and no changes. A scheduler only issues requests and waits for the done pulse. The length of each sequence grows with the size of the register set.

Injected instruction format (32 bits): opcode in bits 31:26, register number in bits 25:21, word offset in bits 15:0. Store is opcode 0x2B and load is opcode 0x23; the data address is the offset. Jump is opcode 0x02 with the target in bits 25:0. Nop is all zeros.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset the block is not busy, done is low, and the core fetch port carries program memory data for the fetch address the core presents.
- R2: A suspend request (valid high, resume low) taken while a task runs makes busy high in the next cycle, and the fetch port then carries injected code instead of program memory.
- R3: During a save, the k-th injected cycle (k from 0 to NREG-1) carries a store of register k to offset k, and task data memory sees no write or read strobe while busy.
- R4: The fetch address the core presents in the first injected save cycle is stored in the slot as the resume point at word NREG.
- R5: A save ends with done high for exactly one cycle, NREG+1 clock edges after the accepting edge, with busy low from then on. The core is then parked on nops.
- R6: During a resume, the injected loads cover registers FIRST to NREG-1 in ascending order (FIRST is 1 when register 0 is hardwired, else 0). Each load returns the word saved for that register in the selected slot.
- R7: The last resume step injects a jump whose target is the saved resume point. Done rises NREG-FIRST+1 edges after the accepting edge, and program memory feeds the fetch port again.
- R8: Requests arriving while busy are ignored. So are a suspend while parked and a resume while a task runs. None of them causes busy, done or injected code.
- R9: Slots are independent: resuming slot s restores exactly the registers and resume point last saved into slot s, whatever was saved into other slots since.
- R10: While a task runs, core stores reach task data memory with unchanged address, data and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one cycle |
| req_resume | input | 1 | 1 = resume, 0 = suspend |
| req_slot | input | SLOTW | Task slot of the request |
| busy | output | 1 | A save or restore sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| proc_iaddr | input | AW | Core fetch address |
| proc_instr | output | 32 | Instruction delivered to the core |
| proc_dwe | input | 1 | Core data write strobe |
| proc_dre | input | 1 | Core data read strobe |
| proc_daddr | input | DAW | Core data word address |
| proc_dwdata | input | DW | Core write data |
| proc_drdata | output | DW | Read data to the core |
| imem_addr | output | AW | Program memory address |
| imem_rdata | input | 32 | Program memory instruction |
| dmem_we | output | 1 | Task data memory write strobe |
| dmem_re | output | 1 | Task data memory read strobe |
| dmem_addr | output | DAW | Task data memory word address |
| dmem_wdata | output | DW | Task data memory write data |
| dmem_rdata | input | DW | Task data memory read data |

## Verification
After the edge that accepts a request, the first injected instruction is visible in the very next cycle. The injected code then advances one step per edge. Done appears NREG+1 edges after the accepting edge for a save and NREG-FIRST+1 edges after it for a restore. The bench drives requests on the falling edge and samples on every following falling edge. It compares each injected instruction, each returned load word and the done cycle against the step number counted from the accepting edge. A behavioral core model in the bench executes the injected code. Its register file and program counter after a restore are compared with snapshots taken when that slot was saved.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  localparam int IW = 32;

  localparam logic [5:0] OP_NOP   = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SAVE = 3'd1,
    ST_PCWR = 3'd2,
    ST_PARK = 3'd3,
    ST_LOAD = 3'd4,
    ST_JUMP = 3'd5
  } seq_state_e;

  function automatic logic [IW-1:0] enc_store(input logic [4:0] r, input logic [15:0] off);
    return {OP_STORE, r, 5'd0, off};
  endfunction

  function automatic logic [IW-1:0] enc_load(input logic [4:0] r, input logic [15:0] off);
    return {OP_LOAD, r, 5'd0, off};
  endfunction

  function automatic logic [IW-1:0] enc_jump(input logic [25:0] tgt);
    return {OP_JUMP, tgt};
  endfunction
endpackage

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int NTASK   = 4,
  parameter int AW      = 16,
  parameter bit ZERO_R0 = 1'b1,
  localparam int CW     = $clog2(NREG),
  localparam int SLOTW  = $clog2(NTASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_resume,
  input  logic [SLOTW-1:0] req_slot,
  input  logic [AW-1:0]    proc_iaddr,
  output seq_state_e       state,
  output logic [CW-1:0]    cnt,
  output logic [SLOTW-1:0] slot,
  output logic [AW-1:0]    pc_hold,
  output logic             done
);
  localparam logic [CW-1:0] LAST  = CW'(NREG - 1);
  localparam logic [CW-1:0] FIRST = ZERO_R0 ? CW'(1) : CW'(0);

  seq_state_e       state_n;
  logic [CW-1:0]    cnt_n;
  logic             slot_en;
  logic             pc_en;
  logic             done_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    slot_en = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (req_valid && !req_resume) begin
          state_n = ST_SAVE;
          cnt_n   = '0;
          slot_en = 1'b1;
        end
      end
      ST_SAVE: begin
        if (cnt == LAST) state_n = ST_PCWR;
        else             cnt_n   = cnt + 1'b1;
      end
      ST_PCWR: state_n = ST_PARK;
      ST_PARK: begin
        if (req_valid && req_resume) begin
          state_n = ST_LOAD;
          cnt_n   = FIRST;
          slot_en = 1'b1;
        end
      end
      ST_LOAD: begin
        if (cnt == LAST) state_n = ST_JUMP;
        else             cnt_n   = cnt + 1'b1;
      end
      ST_JUMP: state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
    pc_en  = (state == ST_SAVE) && (cnt == '0);
    done_n = (state == ST_PCWR) || (state == ST_JUMP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      done  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      pc_hold <= '0;
    end else begin
      if (slot_en) slot    <= req_slot;
      if (pc_en)   pc_hold <= proc_iaddr;
    end
  end
endmodule

// File: rtl/ctxsw_inject.sv
module ctxsw_inject
  import ctxsw_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int CW  = $clog2(NREG)
) (
  input  seq_state_e     state,
  input  logic [CW-1:0]  cnt,
  input  logic [DW-1:0]  resume_word,
  output logic [IW-1:0]  instr
);
  always_comb begin
    unique case (state)
      ST_SAVE: instr = enc_store(5'(cnt), 16'(cnt));
      ST_LOAD: instr = enc_load(5'(cnt), 16'(cnt));
      ST_JUMP: instr = enc_jump(26'(resume_word));
      default: instr = {OP_NOP, 26'd0};
    endcase
  end
endmodule

// File: rtl/ctxsw_store.sv
module ctxsw_store #(
  parameter int DW      = 32,
  parameter int ENTRIES = 132,
  localparam int MAW    = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [MAW-1:0] raddr_a,
  output logic [DW-1:0]  rdata_a,
  input  logic [MAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_b
);
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
  import ctxsw_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int NTASK   = 4,
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int DAW     = 16,
  parameter bit ZERO_R0 = 1'b1,
  localparam int SLOTW  = $clog2(NTASK),
  localparam int CW     = $clog2(NREG),
  localparam int DEPTH  = NREG + 1,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int ENTRIES = NTASK * DEPTH,
  localparam int MAW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_resume,
  input  logic [SLOTW-1:0] req_slot,
  output logic             busy,
  output logic             done,
  input  logic [AW-1:0]    proc_iaddr,
  output logic [IW-1:0]    proc_instr,
  input  logic             proc_dwe,
  input  logic             proc_dre,
  input  logic [DAW-1:0]   proc_daddr,
  input  logic [DW-1:0]    proc_dwdata,
  output logic [DW-1:0]    proc_drdata,
  output logic [AW-1:0]    imem_addr,
  input  logic [IW-1:0]    imem_rdata,
  output logic             dmem_we,
  output logic             dmem_re,
  output logic [DAW-1:0]   dmem_addr,
  output logic [DW-1:0]    dmem_wdata,
  input  logic [DW-1:0]    dmem_rdata
);
  logic [1:0]       rsync;
  logic             rst_int_n;
  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic [SLOTW-1:0] slot;
  logic [AW-1:0]    pc_hold;
  logic             running;
  logic [IW-1:0]    inj_instr;
  logic [MAW-1:0]   slot_base;
  logic [IDXW-1:0]  wr_idx;
  logic             ctx_we;
  logic [MAW-1:0]   ctx_waddr;
  logic [DW-1:0]    ctx_wdata;
  logic [MAW-1:0]   ctx_raddr;
  logic [DW-1:0]    ctx_rdata;
  logic [MAW-1:0]   pc_raddr;
  logic [DW-1:0]    pc_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  ctxsw_seq #(.NREG(NREG), .NTASK(NTASK), .AW(AW), .ZERO_R0(ZERO_R0)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_resume(req_resume),
    .req_slot  (req_slot),
    .proc_iaddr(proc_iaddr),
    .state     (state),
    .cnt       (cnt),
    .slot      (slot),
    .pc_hold   (pc_hold),
    .done      (done)
  );

  ctxsw_inject #(.NREG(NREG), .DW(DW)) u_inject (
    .state      (state),
    .cnt        (cnt),
    .resume_word(pc_word),
    .instr      (inj_instr)
  );

  always_comb begin
    running   = (state == ST_RUN);
    busy      = !(running || (state == ST_PARK));
    slot_base = MAW'(slot) * MAW'(DEPTH);
    wr_idx    = (state == ST_PCWR) ? IDXW'(NREG) : proc_daddr[IDXW-1:0];
    ctx_we    = ((state == ST_SAVE) && proc_dwe) || (state == ST_PCWR);
    ctx_waddr = slot_base + MAW'(wr_idx);
    ctx_wdata = (state == ST_PCWR) ? DW'(pc_hold) : proc_dwdata;
    ctx_raddr = slot_base + MAW'(proc_daddr[IDXW-1:0]);
    pc_raddr  = slot_base + MAW'(NREG);
  end

  ctxsw_store #(.DW(DW), .ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .we     (ctx_we),
    .waddr  (ctx_waddr),
    .wdata  (ctx_wdata),
    .raddr_a(ctx_raddr),
    .rdata_a(ctx_rdata),
    .raddr_b(pc_raddr),
    .rdata_b(pc_word)
  );

  always_comb begin
    imem_addr   = proc_iaddr;
    proc_instr  = running ? imem_rdata : inj_instr;
    dmem_we     = running && proc_dwe;
    dmem_re     = running && proc_dre;
    dmem_addr   = proc_daddr;
    dmem_wdata  = proc_dwdata;
    proc_drdata = running ? dmem_rdata : ctx_rdata;
  end
endmodule

// File: rtl/ctx_switch_ctrl_chk.sv
module ctx_switch_ctrl_chk
  import ctxsw_pkg::*;
#(
  parameter int SLOTW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input seq_state_e       state,
  input logic [SLOTW-1:0] slot,
  input logic             req_valid,
  input logic             req_resume,
  input logic             busy,
  input logic             done,
  input logic [31:0]      proc_instr,
  input logic             dmem_we,
  input logic             dmem_re
);
  assert_accept_suspend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && req_valid && !req_resume) |=> (busy && proc_instr[31:26] == OP_STORE));

  assert_isolate_dmem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!dmem_we && !dmem_re));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_slot_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(slot));
endmodule

bind ctx_switch_ctrl ctx_switch_ctrl_chk #(.SLOTW(SLOTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .state     (state),
  .slot      (slot),
  .req_valid (req_valid),
  .req_resume(req_resume),
  .busy      (busy),
  .done      (done),
  .proc_instr(proc_instr),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re)
);

// File: tb/tb_ctx_switch_ctrl.sv
module tb_ctx_switch_ctrl;
  localparam int NREG  = 32;
  localparam int NTASK = 4;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int DAW   = 16;
  localparam int FIRST = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_resume = 1'b0;
  logic [1:0] req_slot = '0;
  logic busy, done;
  logic [AW-1:0] proc_iaddr, imem_addr;
  logic [31:0] proc_instr, imem_rdata;
  logic proc_dwe, proc_dre, dmem_we, dmem_re;
  logic [DAW-1:0] proc_daddr, dmem_addr;
  logic [DW-1:0] proc_dwdata, proc_drdata, dmem_wdata;
  logic [DW-1:0] dmem_rdata = '0;

  int total = 0, fails = 0;
  logic [31:0] rf [NREG];
  logic [AW-1:0] pc;
  logic [31:0] snap [NTASK][NREG];
  logic [AW-1:0] snap_pc [NTASK];

  always #10 clk = ~clk;

  ctx_switch_ctrl #(.NREG(NREG), .NTASK(NTASK), .DW(DW), .AW(AW), .DAW(DAW), .ZERO_R0(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_resume(req_resume), .req_slot(req_slot),
    .busy(busy), .done(done), .proc_iaddr(proc_iaddr), .proc_instr(proc_instr),
    .proc_dwe(proc_dwe), .proc_dre(proc_dre), .proc_daddr(proc_daddr), .proc_dwdata(proc_dwdata),
    .proc_drdata(proc_drdata), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata));

  function automatic logic [31:0] prog(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai % 5 == 4) return {6'h2B, 5'(ai % 7), 5'd0, 16'(ai & 255)};
    return {6'h08, 5'(ai % 31 + 1), 5'd0, 16'(ai * 3 + 7)};
  endfunction

  function automatic logic [31:0] st_enc(input int r);
    return {6'h2B, 5'(r), 5'd0, 16'(r)};
  endfunction
  function automatic logic [31:0] ld_enc(input int r);
    return {6'h23, 5'(r), 5'd0, 16'(r)};
  endfunction

  // behavioral single-cycle core
  logic [5:0] op;
  logic [4:0] rn;
  always_comb begin
    imem_rdata  = prog(imem_addr);
    proc_iaddr  = pc;
    op          = proc_instr[31:26];
    rn          = proc_instr[25:21];
    proc_dwe    = (op == 6'h2B);
    proc_dre    = (op == 6'h23);
    proc_daddr  = proc_instr[15:0];
    proc_dwdata = rf[rn];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      pc <= pc + 1'b1;
      case (op)
        6'h08: if (rn != 0) rf[rn] <= rf[rn] + {16'd0, proc_instr[15:0]};
        6'h23: if (rn != 0) rf[rn] <= proc_drdata;
        6'h02: pc <= proc_instr[AW-1:0];
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic run(input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk(proc_instr == imem_rdata && imem_addr == proc_iaddr, "R10 fetch passthrough", proc_instr, imem_rdata);
      if (!seen && proc_instr[31:26] == 6'h2B) begin
        seen = 1;
        chk(dmem_we && dmem_addr == DAW'(proc_instr[15:0]) && dmem_wdata == rf[proc_instr[25:21]],
            "R10 store passthrough", {dmem_we, dmem_wdata}, {1'b1, rf[proc_instr[25:21]]});
      end
    end
  endtask

  task automatic suspend(input int s);
    logic [AW-1:0] exp_pc;
    bit ok_seq = 1;
    @(negedge clk);
    req_valid = 1; req_resume = 0; req_slot = 2'(s);
    @(negedge clk);
    req_valid = 0;
    exp_pc = proc_iaddr;
    chk(busy == 1'b1, "R2 busy after suspend accept", busy, 1);
    for (int k = 0; k < NREG; k++) begin
      if (k > 0) @(negedge clk);
      if (proc_instr != st_enc(k) || dmem_we || dmem_re) begin
        ok_seq = 0;
        chk(0, "R3 save step", proc_instr, st_enc(k));
      end
    end
    chk(ok_seq, "R3 save sequence complete", ok_seq, 1);
    @(negedge clk);
    chk(!done && busy, "R5 no early done", done, 0);
    @(negedge clk);
    chk(done && !busy, "R5 done at NREG+1 edges", {busy, done}, 1);
    for (int i = 0; i < NREG; i++) snap[s][i] = rf[i];
    snap_pc[s] = exp_pc;
    @(negedge clk);
    chk(!done && proc_instr == 32'd0, "R5 single pulse then parked", {done, proc_instr}, 0);
  endtask

  task automatic resume(input int s, input bit poke);
    bit ok_seq = 1;
    @(negedge clk);
    req_valid = 1; req_resume = 1; req_slot = 2'(s);
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R6 busy after resume accept", busy, 1);
    for (int r = FIRST; r < NREG; r++) begin
      if (r > FIRST) @(negedge clk);
      if (poke && r == FIRST + 4) begin
        req_valid = 1; req_resume = 0; req_slot = 2'(s + 1);
      end
      if (poke && r == FIRST + 5) req_valid = 0;
      if (proc_instr != ld_enc(r) || proc_drdata != snap[s][r]) begin
        ok_seq = 0;
        chk(0, "R6 load step", {proc_instr, proc_drdata}, {ld_enc(r), snap[s][r]});
      end
    end
    chk(ok_seq, "R6 load sequence from register 1", ok_seq, 1);
    @(negedge clk);
    chk(proc_instr == {6'h02, 26'(snap_pc[s])} && !done, "R7 jump to saved point", proc_instr, {6'h02, 26'(snap_pc[s])});
    @(negedge clk);
    chk(done && !busy, "R7 done at NREG-FIRST+1 edges", {busy, done}, 1);
    chk(pc == snap_pc[s], "R4 resume point restored", pc, snap_pc[s]);
    begin
      bit same = 1;
      for (int i = 0; i < NREG; i++) if (rf[i] != snap[s][i]) same = 0;
      chk(same && rf[0] == 0, "R9 registers of slot restored", same, 1);
    end
    @(negedge clk);
    chk(!done && !busy && proc_instr == imem_rdata, "R8 R7 running again after sequence", {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset idle", {busy, done}, 0);
    chk(proc_instr == prog(proc_iaddr) && imem_addr == proc_iaddr, "R1 reset passthrough", proc_instr, prog(proc_iaddr));

    for (int s = 0; s < NTASK; s++) begin
      run(7 + 3 * s);
      suspend(s);
      if (s < NTASK - 1) resume(s, s == 1);
    end

    // parked: a further suspend must be ignored
    @(negedge clk);
    req_valid = 1; req_resume = 0; req_slot = 2'd0;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !done && proc_instr == 32'd0, "R8 suspend while parked ignored", {busy, done, proc_instr}, 0);
      @(negedge clk);
    end

    for (int k = 0; k < NTASK; k++) begin
      int s = (k * 3 + 2) % NTASK;
      resume(s, 1'b0);
      run(5 + k);
      if (k == 1) begin
        @(negedge clk);
        req_valid = 1; req_resume = 1; req_slot = 2'(s);
        @(negedge clk);
        req_valid = 0;
        chk(!busy && proc_instr == imem_rdata, "R8 resume while running ignored", {busy, proc_instr}, {1'b0, imem_rdata});
        @(negedge clk);
        chk(!busy && !done, "R8 no sequence after ignored resume", {busy, done}, 0);
      end
      suspend(s);
    end

    summary();
  end
endmodule